// File: doc/BRIEF.md
# Parity Error Out-of-Service Monitor

This block sits beside the data path of a packet receiver and watches the parity comparison results the receiver produces. Each cycle a valid strobe says whether a fresh set of results is present, and a vector carries one mismatch bit per lane, since a wide data path checks several parity words per cycle. The block turns that stream into two status outputs. The first is an error pulse that fires whenever any checked lane mismatched. The second is an out-of-service flag with hysteresis: it is raised by a run of consecutive bad cycles and dropped by a separate run of consecutive good ones. The monitor never touches the data, so traffic keeps flowing whatever the flag says.

The hysteresis is a two-state machine. `ST_OUT_OF_SVC` is the reset state. The transition `RECOVER` leads to `ST_IN_SVC` when a valid all-good cycle brings the good-run count up to the good threshold. The transition `DEGRADE` leads back to `ST_OUT_OF_SVC` when a valid cycle with a mismatch brings the bad-run count up to the bad threshold. In every other case the state holds. Both thresholds are captured while reset is high and stay frozen until the next reset.

Top module: `parity_oos_monitor`

## Requirements
- R1: While reset is high and in the first cycle after it, `oos_o` is 1 and `err_o` is 0.
- R2: `err_o` is 1 in the cycle after a cycle with `res_valid_i` = 1 and at least one bit of `mismatch_i` set. After any other cycle it is 0.
- R3: Bit i of `mismatch_i` is the result of lane i, where 1 means a mismatch. A mismatch on any single lane makes the whole cycle a bad result.
- R4: In `ST_IN_SVC`, `oos_o` rises at the clock edge that ends the Nth consecutive valid bad cycle, where N is the bad threshold.
- R5: In `ST_OUT_OF_SVC`, `oos_o` falls at the clock edge that ends the Mth consecutive valid good cycle, where M is the good threshold.
- R6: A valid good cycle restarts the bad-run count, and a valid bad cycle restarts the good-run count.
- R7: A cycle with `res_valid_i` = 0 changes neither run count nor `oos_o`, whatever `mismatch_i` holds.
- R8: The thresholds are taken from `good_thr_i` and `bad_thr_i` only while `rst` is high. Later changes to these inputs have no effect until the next reset.
- R9: A threshold of 0 acts as 1.
- R10: The run counts stop at 15 and do not wrap. A threshold of 15 needs 15 consecutive results, and a longer run keeps the flag where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; thresholds are captured while it is high |
| res_valid_i | input | 1 | The parity results on `mismatch_i` are valid this cycle |
| mismatch_i | input | LANES | Per-lane parity mismatch, where 1 means a mismatch |
| good_thr_i | input | 4 | Consecutive good cycles needed to clear the flag |
| bad_thr_i | input | 4 | Consecutive bad cycles needed to set the flag |
| err_o | output | 1 | Registered pulse: the previous valid cycle had a mismatch |
| oos_o | output | 1 | Out-of-service flag |

## Verification
The embedded assertions check on every cycle that the error pulse follows the valid mismatch of the previous cycle, and that the flag only rises after a valid bad cycle and only falls after a valid good one. They also check that invalid cycles leave the flag alone, that the captured thresholds stay frozen and non-zero after reset, and that a saturated counter stays at its maximum. The exact cycle on which a run reaches its threshold, the restart of a run when the opposite result arrives, the state out of reset, and the effect of changing the threshold inputs after reset can only be shown by the bench's directed scenarios, which compare the flag with counts worked out by hand.

// File: rtl/oos_pkg.sv
package oos_pkg;

    localparam int THR_W = 4;

    typedef enum logic [0:0] {
        ST_IN_SVC     = 1'b0,
        ST_OUT_OF_SVC = 1'b1
    } oos_state_e;

endpackage

// File: rtl/oos_thr_latch.sv
module oos_thr_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] thr_i,
    output logic [W-1:0] thr_o
);

    localparam logic [W-1:0] ONE = W'(1);

    // A zero request is promoted so one event always suffices (R9).
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_o <= (thr_i == '0) ? ONE : thr_i;
        end
    end

    // R8: frozen outside reset
    p_thr_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(thr_o));

    // R9: never zero once reset has run
    p_thr_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        thr_o != '0);

endmodule

// File: rtl/oos_run_counter.sv
module oos_run_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic         hit_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    // A valid hit extends the run, a valid miss restarts it, and an
    // invalid cycle holds it (R6, R7, R10).
    always_comb begin
        cnt_next_o = cnt_q;
        if (valid_i) begin
            if (!hit_i) begin
                cnt_next_o = '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_next_o = cnt_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next_o;
        end
    end

    assign cnt_o = cnt_q;

    // R10: saturation, no wrap
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && valid_i && hit_i) |=> cnt_q == CNT_MAX);

    // R7: invalid cycles hold the count
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(cnt_q));

    // R6: a miss restarts the run
    p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !hit_i) |=> cnt_q == '0);

endmodule

// File: rtl/oos_fsm.sv
module oos_fsm
    import oos_pkg::*;
#(
    parameter int W = THR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic         bad_i,
    input  logic [W-1:0] good_next_i,
    input  logic [W-1:0] bad_next_i,
    input  logic [W-1:0] good_thr_i,
    input  logic [W-1:0] bad_thr_i,
    output logic         oos_o
);

    oos_state_e state_q, state_d;
    logic       degrade, recover;

    assign degrade = valid_i &&  bad_i && (bad_next_i  >= bad_thr_i);
    assign recover = valid_i && !bad_i && (good_next_i >= good_thr_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IN_SVC:     if (degrade) state_d = ST_OUT_OF_SVC;
            ST_OUT_OF_SVC: if (recover) state_d = ST_IN_SVC;
            default:       state_d = ST_OUT_OF_SVC;
        endcase
    end

    // State register: start out of service (R1).
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OUT_OF_SVC;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_IN_SVC:     oos_o = 1'b0;
            ST_OUT_OF_SVC: oos_o = 1'b1;
            default:       oos_o = 1'b1;
        endcase
    end

    // R4: flag only rises after a valid bad cycle
    p_rise_on_bad_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(oos_o) |-> $past(valid_i && bad_i));

    // R5: flag only falls after a valid good cycle
    p_fall_on_good_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(oos_o) |-> $past(valid_i && !bad_i));

    // R7: invalid cycles leave the flag alone
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(oos_o));

endmodule

// File: rtl/parity_oos_monitor.sv
module parity_oos_monitor
    import oos_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid_i,
    input  logic [LANES-1:0] mismatch_i,
    input  logic [THR_W-1:0] good_thr_i,
    input  logic [THR_W-1:0] bad_thr_i,
    output logic             err_o,
    output logic             oos_o
);

    localparam int NCNT = 2;   // index 0: good run, index 1: bad run

    logic             bad_cyc;
    logic [THR_W-1:0] thr_raw [NCNT];
    logic [THR_W-1:0] thr_q   [NCNT];
    logic [THR_W-1:0] cnt     [NCNT];
    logic [THR_W-1:0] cnt_nx  [NCNT];
    logic             hit     [NCNT];

    // Any lane mismatch marks the cycle bad (R3).
    assign bad_cyc = |mismatch_i;

    assign thr_raw[0] = good_thr_i;
    assign thr_raw[1] = bad_thr_i;
    assign hit[0]     = !bad_cyc;
    assign hit[1]     =  bad_cyc;

    for (genvar g = 0; g < NCNT; g++) begin : g_run
        oos_thr_latch #(.W(THR_W)) u_thr (
            .clk   (clk),
            .rst   (rst),
            .thr_i (thr_raw[g]),
            .thr_o (thr_q[g])
        );

        oos_run_counter #(.W(THR_W)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .valid_i    (res_valid_i),
            .hit_i      (hit[g]),
            .cnt_o      (cnt[g]),
            .cnt_next_o (cnt_nx[g])
        );
    end

    oos_fsm #(.W(THR_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (res_valid_i),
        .bad_i       (bad_cyc),
        .good_next_i (cnt_nx[0]),
        .bad_next_i  (cnt_nx[1]),
        .good_thr_i  (thr_q[0]),
        .bad_thr_i   (thr_q[1]),
        .oos_o       (oos_o)
    );

    // Registered error pulse (R2).
    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= 1'b0;
        end else begin
            err_o <= res_valid_i && bad_cyc;
        end
    end

    // R2: pulse follows a valid mismatch
    p_err_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (res_valid_i && (mismatch_i != '0)) |=> err_o);

    // R2: no pulse without one
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_i && (mismatch_i != '0)) |=> !err_o);

    // R6: the two runs are never both in progress
    p_runs_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt[0] == '0) || (cnt[1] == '0));

endmodule

// File: tb/tb_parity_oos_monitor.sv
module tb_parity_oos_monitor;

    localparam int LANES = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             res_valid_i = 1'b0;
    logic [LANES-1:0] mismatch_i = '0;
    logic [3:0]       good_thr_i = 4'd3;
    logic [3:0]       bad_thr_i  = 4'd2;
    logic             err_o, oos_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    parity_oos_monitor #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .res_valid_i(res_valid_i), .mismatch_i(mismatch_i),
        .good_thr_i(good_thr_i), .bad_thr_i(bad_thr_i), .err_o(err_o), .oos_o(oos_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs are read at the next one.
    task automatic step(input logic v, input logic [LANES-1:0] mm);
        res_valid_i = v;
        mismatch_i  = mm;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] g, input logic [3:0] b);
        @(negedge clk);
        rst = 1'b1; res_valid_i = 1'b0; mismatch_i = '0;
        good_thr_i = g; bad_thr_i = b;
        @(negedge clk);
        @(negedge clk);
        chk(oos_o, 1'b1, "R1", "flag in reset");
        chk(err_o, 1'b0, "R1", "err in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(oos_o, 1'b1, "R1", "flag after reset");
    endtask

    task automatic t_recover_and_degrade();
        do_reset(4'd3, 4'd2);
        step(1, 4'b0000); step(1, 4'b0000);
        chk(oos_o, 1'b1, "R5", "two goods of three");
        chk(err_o, 1'b0, "R2", "no err on good");
        step(1, 4'b0000);
        chk(oos_o, 1'b0, "R5", "third good clears");
        step(1, 4'b0010);
        chk(err_o, 1'b1, "R3", "lane 1 mismatch pulses err");
        chk(oos_o, 1'b0, "R4", "one bad of two");
        step(1, 4'b0000);
        chk(err_o, 1'b0, "R2", "err drops after good");
        step(1, 4'b1000);
        chk(oos_o, 1'b0, "R6", "good broke bad run");
        step(1, 4'b0001);
        chk(oos_o, 1'b1, "R4", "second consecutive bad sets");
    endtask

    task automatic t_invalid_ignored();
        // flag is set here; good count starts at 0
        step(1, 4'b0000); step(1, 4'b0000);
        for (int i = 0; i < 3; i++) begin
            step(0, 4'b1111);
            chk(err_o, 1'b0, "R7", "invalid mismatch no err");
            chk(oos_o, 1'b1, "R7", "invalid holds flag");
        end
        step(1, 4'b0000);
        chk(oos_o, 1'b0, "R7", "good run survived invalid cycles");
    endtask

    task automatic t_good_run_broken();
        do_reset(4'd3, 4'd2);
        step(1, 4'b0000); step(1, 4'b0000); step(1, 4'b0100);
        step(1, 4'b0000); step(1, 4'b0000);
        chk(oos_o, 1'b1, "R6", "bad broke good run");
        step(1, 4'b0000);
        chk(oos_o, 1'b0, "R6", "fresh run of three clears");
    endtask

    task automatic t_thr_frozen();
        do_reset(4'd2, 4'd2);
        good_thr_i = 4'd9; bad_thr_i = 4'd1;
        step(1, 4'b0000); step(1, 4'b0000);
        chk(oos_o, 1'b0, "R8", "good threshold stayed 2");
        step(1, 4'b0001);
        chk(oos_o, 1'b0, "R8", "bad threshold stayed 2");
        step(1, 4'b0001);
        chk(oos_o, 1'b1, "R8", "second bad sets");
    endtask

    task automatic t_zero_thr();
        do_reset(4'd0, 4'd0);
        step(1, 4'b0000);
        chk(oos_o, 1'b0, "R9", "one good clears with zero thr");
        step(1, 4'b0010);
        chk(oos_o, 1'b1, "R9", "one bad sets with zero thr");
    endtask

    task automatic t_saturate();
        do_reset(4'd15, 4'd15);
        for (int i = 0; i < 14; i++) step(1, 4'b0000);
        chk(oos_o, 1'b1, "R10", "14 goods of 15");
        step(1, 4'b0000);
        chk(oos_o, 1'b0, "R10", "15th good clears");
        for (int i = 0; i < 14; i++) step(1, 4'b1000);
        chk(oos_o, 1'b0, "R10", "14 bads of 15");
        step(1, 4'b1000);
        chk(oos_o, 1'b1, "R10", "15th bad sets");
        for (int i = 0; i < 6; i++) step(1, 4'b1000);
        chk(oos_o, 1'b1, "R10", "long bad run holds flag");
        for (int i = 0; i < 14; i++) step(1, 4'b0000);
        chk(oos_o, 1'b1, "R10", "14 goods after saturation");
        step(1, 4'b0000);
        chk(oos_o, 1'b0, "R10", "15 goods clear after saturation");
    endtask

    initial begin
        t_recover_and_degrade();
        t_invalid_ignored();
        t_good_run_broken();
        t_thr_frozen();
        t_zero_thr();
        t_saturate();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule